// File: doc/BRIEF.md
# Move Machine Sequencer

This block is a small fetch/execute engine whose only instruction is a memory-to-memory word move. A program is a list of move descriptors held in ordinary RAM. The fetch side reads one descriptor and loads it into the execute side's working registers. The execute side then performs the move over a single-master, word-aligned memory bus. A re-arm step follows, and then the next descriptor is fetched. The program counter is the fetch side's read address. It is also visible as one register address on the bus map, so a jump is an ordinary move whose destination is that address. A conditional jump is a move of a computed target address, so every outcome of the condition must lead to a jump.

Each descriptor is four 32-bit words at consecutive byte addresses and occupies 16 bytes. Per-descriptor options cover the transfer width, a byte swap, a tap that feeds each moved word to an external observer, and pacing of every transfer by a timer request. The engine has no prefetch. A move that rewrites descriptor words further down the program therefore takes effect when those words are fetched later.

Top module: `mm_move_engine`

## Requirements
- R1: A descriptor at program counter P is read as source address (P), destination address (P+4), repeat count (P+8) and control word (P+12), in that order. After the fourth word is read, P has advanced by 16.
- R2: While idle, a one-cycle `start` loads the program counter from `start_pc` and begins fetching. After reset `running` is low and the bus is idle.
- R3: If control bit 0 (enable) is clear, the engine stops with `running` low and moves nothing. `pc_out` then points 16 bytes past that descriptor.
- R4: The move is repeated as many times as the repeat count gives, with the same source and destination each time. A count of zero moves nothing, and execution continues with the next descriptor.
- R5: If control bit 2 (swap) is set in 32-bit mode, the written word has its bytes reversed: bits 31:24 change places with 7:0, and 23:16 with 15:8.
- R6: If control bit 1 (half) is set, only the low 16 bits are written (`bus_be` = 0011) and the upper destination bytes keep their value. With swap also set, the two low bytes change places.
- R7: If control bit 3 (observe) is set, `obs_valid` pulses once per transferred word, and `obs_data` carries the word as written. With the bit clear, `obs_valid` stays low.
- R8: A move whose destination equals `PC_ADDR` replaces the program counter with the moved word and never appears as a bus write. This is how a jump is made.
- R9: If control bit 4 (paced) is set, each transfer waits for `pace_req` high. While it waits, nothing is written.
- R10: A descriptor is fetched only after the previous move has completed, so a move into later program words changes what is executed. Each bus write is preceded by the read of its word, so no two consecutive cycles carry writes.
- R11: `halt_req` stops the engine at the end of the descriptor in progress. The program counter is then left on the next descriptor to be fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| start_pc | input | ADDR_W | Program counter value loaded on start |
| halt_req | input | 1 | Stop at the next descriptor boundary |
| pace_req | input | 1 | Timer pacing request for paced descriptors |
| bus_en | output | 1 | Bus access this cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address, word aligned |
| bus_wdata | output | 32 | Write data |
| bus_be | output | 4 | Byte enables for writes |
| bus_rdata | input | 32 | Read data, valid the cycle after a read |
| obs_valid | output | 1 | Observer tap strobe |
| obs_data | output | 32 | Word seen by the observer |
| running | output | 1 | Engine is executing a program |
| pc_out | output | ADDR_W | Current program counter |

## Verification
The copy path is exercised with a plain 32-bit move, a reversed-byte move, a half-width move and a half-width swapped move. All four read the same source, so a wrong byte lane or a wrong strobe shows up as a distinct destination value. Repeat counts of three, zero and two separate "repeat with fixed addresses" from "skip" and from "move once", and the observer count separates observed descriptors from unobserved ones. Control flow is tried in four ways: a jump that must skip a marker descriptor, a move that disables a later descriptor before it is fetched, a paced move released one timer pulse at a time, and a tight loop stopped by `halt_req`. Together these show whether the program counter, the fetch ordering and the stop paths each act at the intended boundary.

// File: rtl/mm_pkg.sv
package mm_pkg;

  // Control word bit positions (the fields the sequencer decodes)
  localparam int CTL_ENABLE  = 0;
  localparam int CTL_HALF    = 1;
  localparam int CTL_SWAP    = 2;
  localparam int CTL_OBSERVE = 3;
  localparam int CTL_PACED   = 4;
  localparam int CTL_W       = 5;

  localparam int DESC_WORDS  = 4;
  localparam int DESC_BYTES  = DESC_WORDS * 4;

  typedef struct packed {
    logic paced;
    logic observe;
    logic swap;
    logic half;
    logic enable;
  } ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_FDAT,
    ST_CHAIN,
    ST_PACE,
    ST_XRD,
    ST_XWR,
    ST_REARM
  } seq_state_e;

  function automatic logic [31:0] swap_word(input logic [31:0] w, input logic half);
    if (half) swap_word = {w[31:16], w[7:0], w[15:8]};
    else      swap_word = {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/mm_desc_regs.sv
module mm_desc_regs #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pc_set,
  input  logic [ADDR_W-1:0]   pc_set_val,
  input  logic                word_cap,
  input  logic [31:0]         rdata,
  input  logic                rearm,
  input  logic                cnt_load,
  input  logic                cnt_dec,
  output logic [ADDR_W-1:0]   pc,
  output logic [ADDR_W-1:0]   fetch_addr,
  output logic                last_word,
  output logic [ADDR_W-1:0]   src_addr,
  output logic [ADDR_W-1:0]   dst_addr,
  output mm_pkg::ctl_t        ctl,
  output logic                cnt_zero,
  output logic                last_xfer
);
  import mm_pkg::*;

  localparam int IDX_W  = $clog2(DESC_WORDS);
  localparam int ADDR_WORDS = DESC_WORDS - 1;   // words held at full width
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [31:0]       word_q [ADDR_WORDS];
  ctl_t              ctl_q;

  assign last_word = (idx_q == LAST_IDX);

  // next-state
  always_comb begin
    pc_d = pc_q;
    if (pc_set)                     pc_d = pc_set_val;
    else if (word_cap && last_word) pc_d = pc_q + ADDR_W'(DESC_BYTES);
  end

  always_comb begin
    idx_d = idx_q;
    if (rearm)         idx_d = '0;
    else if (word_cap) idx_d = idx_q + 1'b1;
  end

  always_comb begin
    rem_d = rem_q;
    if (cnt_load)     rem_d = word_q[2][CNT_W-1:0];
    else if (cnt_dec) rem_d = rem_q - 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      idx_q <= '0;
      rem_q <= '0;
    end else begin
      pc_q  <= pc_d;
      idx_q <= idx_d;
      rem_q <= rem_d;
    end
  end

  for (genvar gi = 0; gi < ADDR_WORDS; gi++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   word_q[gi] <= '0;
      else if (word_cap && idx_q == IDX_W'(gi))     word_q[gi] <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ctl_q <= '0;
    else if (word_cap && last_word)    ctl_q <= ctl_t'(rdata[CTL_W-1:0]);
  end

  assign pc         = pc_q;
  assign fetch_addr = pc_q + {idx_q, 2'b00};
  assign src_addr   = word_q[0][ADDR_W-1:0];
  assign dst_addr   = word_q[1][ADDR_W-1:0];
  assign ctl        = ctl_q;
  assign cnt_zero   = (word_q[2][CNT_W-1:0] == '0);
  assign last_xfer  = (rem_q == CNT_W'(1));

endmodule

// File: rtl/mm_xfer_path.sv
module mm_xfer_path #(
  parameter int          ADDR_W  = 32,
  parameter logic [31:0] PC_ADDR = 32'h0000_FFF0
) (
  input  mm_pkg::ctl_t       ctl,
  input  logic [ADDR_W-1:0]  dst_addr,
  input  logic [31:0]        rdata,
  output logic [31:0]        wdata,
  output logic [3:0]         be,
  output logic               to_pc,
  output logic [ADDR_W-1:0]  jump_pc
);
  import mm_pkg::*;

  logic [31:0] swapped;

  always_comb begin
    swapped = ctl.swap ? swap_word(rdata, ctl.half) : rdata;
    if (ctl.half) begin
      wdata = {16'h0000, swapped[15:0]};
      be    = 4'b0011;
    end else begin
      wdata = swapped;
      be    = 4'b1111;
    end
  end

  assign to_pc   = (dst_addr == PC_ADDR[ADDR_W-1:0]);
  assign jump_pc = wdata[ADDR_W-1:0];

endmodule

// File: rtl/mm_seq_fsm.sv
module mm_seq_fsm (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               halt_req,
  input  logic               pace_req,
  input  logic               last_word,
  input  mm_pkg::ctl_t       ctl,
  input  logic               cnt_zero,
  input  logic               last_xfer,
  output mm_pkg::seq_state_e state
);
  import mm_pkg::*;

  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_FREQ;
      ST_FREQ:  st_d = ST_FDAT;
      ST_FDAT:  st_d = last_word ? ST_CHAIN : ST_FREQ;
      ST_CHAIN: begin
        if (!ctl.enable)   st_d = ST_IDLE;
        else if (cnt_zero) st_d = ST_REARM;
        else if (ctl.paced) st_d = ST_PACE;
        else               st_d = ST_XRD;
      end
      ST_PACE:  if (pace_req) st_d = ST_XRD;
      ST_XRD:   st_d = ST_XWR;
      ST_XWR: begin
        if (last_xfer)      st_d = ST_REARM;
        else if (ctl.paced) st_d = ST_PACE;
        else                st_d = ST_XRD;
      end
      ST_REARM: st_d = halt_req ? ST_IDLE : ST_FREQ;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/mm_move_engine.sv
module mm_move_engine #(
  parameter int          ADDR_W  = 32,
  parameter int          CNT_W   = 32,
  parameter logic [31:0] PC_ADDR = 32'h0000_FFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic              halt_req,
  input  logic              pace_req,
  output logic              bus_en,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic [3:0]        bus_be,
  input  logic [31:0]       bus_rdata,
  output logic              obs_valid,
  output logic [31:0]       obs_data,
  output logic              running,
  output logic [ADDR_W-1:0] pc_out
);
  import mm_pkg::*;

  seq_state_e        state;
  ctl_t              ctl;
  logic [ADDR_W-1:0] pc, fetch_addr, src_addr, dst_addr, jump_pc, pc_set_val;
  logic              last_word, cnt_zero, last_xfer, to_pc;
  logic              go, pc_set, word_cap, rearm, cnt_load, cnt_dec;
  logic [31:0]       wdata;
  logic [3:0]        be;

  assign go         = (state == ST_IDLE) && start;
  assign word_cap   = (state == ST_FDAT);
  assign cnt_load   = (state == ST_CHAIN);
  assign cnt_dec    = (state == ST_XWR);
  assign rearm      = go || (state == ST_REARM);
  assign pc_set     = go || ((state == ST_XWR) && to_pc);
  assign pc_set_val = go ? start_pc : jump_pc;

  mm_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .halt_req  (halt_req),
    .pace_req  (pace_req),
    .last_word (last_word),
    .ctl       (ctl),
    .cnt_zero  (cnt_zero),
    .last_xfer (last_xfer),
    .state     (state)
  );

  mm_desc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_desc (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_set     (pc_set),
    .pc_set_val (pc_set_val),
    .word_cap   (word_cap),
    .rdata      (bus_rdata),
    .rearm      (rearm),
    .cnt_load   (cnt_load),
    .cnt_dec    (cnt_dec),
    .pc         (pc),
    .fetch_addr (fetch_addr),
    .last_word  (last_word),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .ctl        (ctl),
    .cnt_zero   (cnt_zero),
    .last_xfer  (last_xfer)
  );

  mm_xfer_path #(.ADDR_W(ADDR_W), .PC_ADDR(PC_ADDR)) u_xfer (
    .ctl      (ctl),
    .dst_addr (dst_addr),
    .rdata    (bus_rdata),
    .wdata    (wdata),
    .be       (be),
    .to_pc    (to_pc),
    .jump_pc  (jump_pc)
  );

  // bus steering
  always_comb begin
    bus_en    = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = fetch_addr;
    bus_wdata = wdata;
    bus_be    = be;
    unique case (state)
      ST_FREQ: bus_en = 1'b1;
      ST_XRD: begin
        bus_en   = 1'b1;
        bus_addr = src_addr;
      end
      ST_XWR: begin
        bus_en   = !to_pc;
        bus_we   = !to_pc;
        bus_addr = dst_addr;
      end
      default: ;
    endcase
  end

  assign obs_valid = (state == ST_XWR) && ctl.observe;
  assign obs_data  = wdata;
  assign running   = (state != ST_IDLE);
  assign pc_out    = pc;

endmodule

// File: rtl/mm_move_engine_sva.sv
module mm_move_engine_sva #(
  parameter int          ADDR_W  = 32,
  parameter logic [31:0] PC_ADDR = 32'h0000_FFF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] start_pc,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic              obs_valid,
  input logic              running,
  input logic [ADDR_W-1:0] pc_out
);

  // R2: a run begins with the program counter taken from start_pc
  a_r2_start_loads_pc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (pc_out == $past(start_pc)));

  // R2: an idle engine leaves the bus alone
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !bus_en);

  // R8: program counter writes never reach the bus
  a_r8_no_pc_bus_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we) |-> (bus_addr != PC_ADDR[ADDR_W-1:0]));

  // R6: writes are either full word or low half
  a_r6_strobe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we) |-> (bus_be == 4'b1111 || bus_be == 4'b0011));

  // R10: every write follows a read cycle
  a_r10_no_back_to_back_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we) |=> !(bus_en && bus_we));

  // R7: observer only fires inside a run
  a_r7_obs_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    obs_valid |-> running);

endmodule

bind mm_move_engine mm_move_engine_sva #(.ADDR_W(ADDR_W), .PC_ADDR(PC_ADDR)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_pc  (start_pc),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .obs_valid (obs_valid),
  .running   (running),
  .pc_out    (pc_out)
);

// File: tb/tb_mm_move_engine.sv
module tb_mm_move_engine;
  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 32;
  localparam logic [31:0] PC_ADDR    = 32'h0000_FFF0;
  localparam logic [31:0] EN = 32'h1, HALF = 32'h2, SWAP = 32'h4, OBS = 32'h8, PACE = 32'h10;

  logic clk = 1'b0;
  logic rst_n, start, halt_req, pace_req;
  logic [ADDR_W-1:0] start_pc;
  logic bus_en, bus_we, obs_valid, running;
  logic [ADDR_W-1:0] bus_addr, pc_out;
  logic [31:0] bus_wdata, bus_rdata, obs_data;
  logic [3:0] bus_be;

  logic        ld_we;
  logic [31:0] ld_addr, ld_data;
  logic [31:0] mem [1024];
  logic [31:0] watch_addr;
  int watch_cnt = 0, pcw_cnt = 0, obs_cnt = 0;
  logic [31:0] obs_last;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_move_engine #(.ADDR_W(ADDR_W), .PC_ADDR(PC_ADDR)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
    .halt_req(halt_req), .pace_req(pace_req),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_rdata(bus_rdata), .obs_valid(obs_valid), .obs_data(obs_data),
    .running(running), .pc_out(pc_out)
  );

  // memory model, one-cycle read latency, byte strobes
  always @(posedge clk) begin
    if (ld_we) mem[ld_addr[11:2]] <= ld_data;
    else if (bus_en && bus_we) begin
      if (bus_be[0]) mem[bus_addr[11:2]][7:0]   <= bus_wdata[7:0];
      if (bus_be[1]) mem[bus_addr[11:2]][15:8]  <= bus_wdata[15:8];
      if (bus_be[2]) mem[bus_addr[11:2]][23:16] <= bus_wdata[23:16];
      if (bus_be[3]) mem[bus_addr[11:2]][31:24] <= bus_wdata[31:24];
    end
    if (bus_en && !bus_we) bus_rdata <= mem[bus_addr[11:2]];
  end

  // monitors
  always @(posedge clk) begin
    if (bus_en && bus_we && bus_addr == watch_addr) watch_cnt <= watch_cnt + 1;
    if (bus_en && bus_we && bus_addr == PC_ADDR)    pcw_cnt   <= pcw_cnt + 1;
    if (obs_valid) begin
      obs_cnt  <= obs_cnt + 1;
      obs_last <= obs_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem[a[11:2]];
  endfunction

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] cnt, input logic [31:0] ctl);
    poke(base, src); poke(base + 4, dst); poke(base + 8, cnt); poke(base + 12, ctl);
  endtask

  task automatic kick(input logic [31:0] pc);
    @(negedge clk);
    start = 1'b1; start_pc = pc;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input int max_cyc);
    for (int i = 0; i < max_cyc; i++) begin
      if (!running) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(!running, "R2 reset running", 32'(running), 0);
    chk(!bus_en, "R2 reset bus idle", 32'(bus_en), 0);
  endtask

  task automatic t_copy_and_halt;
    poke(32'h300, 32'hCAFE_F00D); poke(32'h340, 0); poke(32'h344, 0);
    put_desc(32'h00, 32'h300, 32'h340, 1, EN);
    put_desc(32'h10, 32'h300, 32'h344, 1, 32'h0);
    kick(0); wait_idle(200);
    chk(peek(32'h340) == 32'hCAFE_F00D, "R1 plain copy", peek(32'h340), 32'hCAFE_F00D);
    chk(!running, "R3 stopped", 32'(running), 0);
    chk(pc_out == 32'h20, "R3 pc past halt descriptor", pc_out, 32'h20);
    chk(peek(32'h344) == 0, "R3 disabled move not done", peek(32'h344), 0);
  endtask

  task automatic t_swap_half;
    poke(32'h300, 32'h1122_3344); poke(32'h304, 32'h1234_5678);
    poke(32'h348, 0); poke(32'h34C, 32'hAAAA_AAAA); poke(32'h350, 32'hAAAA_AAAA);
    put_desc(32'h00, 32'h300, 32'h348, 1, EN | SWAP);
    put_desc(32'h10, 32'h304, 32'h34C, 1, EN | HALF);
    put_desc(32'h20, 32'h304, 32'h350, 1, EN | HALF | SWAP);
    put_desc(32'h30, 0, 0, 0, 0);
    kick(0); wait_idle(300);
    chk(peek(32'h348) == 32'h4433_2211, "R5 word byte swap", peek(32'h348), 32'h4433_2211);
    chk(peek(32'h34C) == 32'hAAAA_5678, "R6 half width", peek(32'h34C), 32'hAAAA_5678);
    chk(peek(32'h350) == 32'hAAAA_7856, "R6 half width swap", peek(32'h350), 32'hAAAA_7856);
  endtask

  task automatic t_count_observe;
    int w0, o0;
    poke(32'h300, 32'h5); poke(32'h360, 0); poke(32'h364, 0); poke(32'h368, 0);
    put_desc(32'h00, 32'h300, 32'h360, 3, EN | OBS);
    put_desc(32'h10, 32'h300, 32'h364, 0, EN | OBS);
    put_desc(32'h20, 32'h300, 32'h368, 2, EN);
    put_desc(32'h30, 0, 0, 0, 0);
    watch_addr = 32'h360;
    @(negedge clk);
    w0 = watch_cnt; o0 = obs_cnt;
    kick(0); wait_idle(300);
    chk(watch_cnt - w0 == 3, "R4 repeat count writes", 32'(watch_cnt - w0), 3);
    chk(peek(32'h364) == 0, "R4 zero count moves nothing", peek(32'h364), 0);
    chk(peek(32'h368) == 5, "R4 continues after zero count", peek(32'h368), 5);
    chk(obs_cnt - o0 == 3, "R7 observer pulses only when enabled", 32'(obs_cnt - o0), 3);
    chk(obs_last == 5, "R7 observer data", obs_last, 5);
  endtask

  task automatic t_jump;
    int p0;
    poke(32'h300, 32'h40); poke(32'h304, 32'h1111); poke(32'h370, 0); poke(32'h374, 0);
    put_desc(32'h00, 32'h300, PC_ADDR, 1, EN);
    put_desc(32'h10, 32'h304, 32'h370, 1, EN);
    put_desc(32'h20, 0, 0, 0, 0);
    put_desc(32'h40, 32'h304, 32'h374, 1, EN);
    put_desc(32'h50, 0, 0, 0, 0);
    @(negedge clk); p0 = pcw_cnt;
    kick(0); wait_idle(300);
    chk(peek(32'h370) == 0, "R8 skipped descriptor", peek(32'h370), 0);
    chk(peek(32'h374) == 32'h1111, "R8 jump target ran", peek(32'h374), 32'h1111);
    chk(pc_out == 32'h60, "R8 pc after jump", pc_out, 32'h60);
    chk(pcw_cnt == p0, "R8 no bus write to pc", 32'(pcw_cnt - p0), 0);
  endtask

  task automatic t_selfmod;
    poke(32'h304, 32'h2222); poke(32'h308, 0); poke(32'h378, 0);
    put_desc(32'h00, 32'h308, 32'h1C, 1, EN);
    put_desc(32'h10, 32'h304, 32'h378, 1, EN);
    put_desc(32'h20, 0, 0, 0, 0);
    kick(0); wait_idle(300);
    chk(peek(32'h378) == 0, "R10 rewritten descriptor not moved", peek(32'h378), 0);
    chk(pc_out == 32'h20, "R10 halted at rewritten descriptor", pc_out, 32'h20);
  endtask

  task automatic t_pace;
    int w0;
    poke(32'h300, 32'h77); poke(32'h380, 0);
    put_desc(32'h00, 32'h300, 32'h380, 2, EN | PACE);
    put_desc(32'h10, 0, 0, 0, 0);
    watch_addr = 32'h380;
    @(negedge clk); w0 = watch_cnt;
    kick(0);
    repeat (40) @(negedge clk);
    chk(running, "R9 waiting for pace", 32'(running), 1);
    chk(watch_cnt - w0 == 0, "R9 no write before pace", 32'(watch_cnt - w0), 0);
    pace_req = 1'b1; @(negedge clk); pace_req = 1'b0;
    repeat (30) @(negedge clk);
    chk(watch_cnt - w0 == 1, "R9 one write per pace pulse", 32'(watch_cnt - w0), 1);
    pace_req = 1'b1; @(negedge clk); pace_req = 1'b0;
    wait_idle(100);
    chk(watch_cnt - w0 == 2, "R9 second pulse completes", 32'(watch_cnt - w0), 2);
    chk(!running, "R9 ends after count", 32'(running), 0);
  endtask

  task automatic t_halt;
    poke(32'h30C, 0);
    put_desc(32'h00, 32'h300, 32'h384, 1, EN);
    put_desc(32'h10, 32'h30C, PC_ADDR, 1, EN);
    kick(0);
    repeat (100) @(negedge clk);
    chk(running, "R11 loop still running", 32'(running), 1);
    halt_req = 1'b1;
    wait_idle(100);
    halt_req = 1'b0;
    chk(!running, "R11 halt request stops", 32'(running), 0);
    chk(pc_out == 0 || pc_out == 32'h10, "R11 pc on next descriptor", pc_out, 32'h10);
  endtask

  task automatic t_start_pc;
    poke(32'h300, 32'hBEEF); poke(32'h388, 0);
    put_desc(32'h80, 32'h300, 32'h388, 1, EN);
    put_desc(32'h90, 0, 0, 0, 0);
    kick(32'h80); wait_idle(200);
    chk(peek(32'h388) == 32'hBEEF, "R2 start_pc program ran", peek(32'h388), 32'hBEEF);
    chk(pc_out == 32'hA0, "R2 pc from start_pc", pc_out, 32'hA0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start_pc = '0; halt_req = 1'b0; pace_req = 1'b0;
    ld_we = 1'b0; ld_addr = '0; ld_data = '0; watch_addr = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy_and_halt();
    t_swap_half();
    t_count_observe();
    t_jump();
    t_selfmod();
    t_pace();
    t_halt();
    t_start_pc();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule